// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block sits beside a peripheral on a microcontroller bus. It watches the address-latch-enable (ALE) strobe and puts the peripheral into a low-power state once the bus has gone quiet. Many controllers freeze ALE at a fixed level when they stop. The block counts ticks while ALE rests at a programmed idle level. After fifteen idle ticks it raises a power-down output. It also raises a deeper sleep output if that level is enabled. Any transition on ALE clears the count and releases both outputs.

The tick source can be chosen at run time. It is either every cycle of the main clock, or each rising edge of a slower clock taken from an external pin. The external pin clock is synchronized and edge-detected, so all logic runs on the main clock and the tick acts as a clock enable.

A separate active-low chip select gives the host direct control. While chip select is high, power-down is forced and the bus-gate enable is dropped, which blocks address and control inputs. This path is combinational. Two mode registers are loaded through a simple address/data/write-strobe port.

Top module: `apd_ctrl`

## Requirements
- R1: After reset, both mode registers read as zero: auto power-down is disabled, the idle level is low, sleep is disabled and the external pin clock is selected. `sleep` is 0, and `pd` and `bus_en` follow chip select only.
- R2: A write with `wr_addr`=0 loads mode register 0, in which bit 1 is the ALE idle level, bit 2 is the auto power-down enable and bit 3 is the sleep enable. A write with `wr_addr`=1 loads mode register 1, in which only bit 0 (tick source, 1 = main clock) has an effect.
- R3: While the auto power-down enable is 0, `pd` never rises from the idle counter, however long ALE stays idle.
- R4: With the main clock selected and ALE at the idle level, `pd` rises on the 15th clock edge after the register write that enables the function, and not before.
- R5: With the external pin clock selected, only rising edges of that pin advance the counter, and `pd` rises after the 15th such edge. Main-clock cycles alone never advance it.
- R6: While ALE rests at the level opposite the programmed idle level, the counter stays at zero and `pd` stays low.
- R7: Once the counter has reached 15 it stays there, and `pd` stays high until ALE moves or reset.
- R8: A transition of ALE clears the counter. `pd` and `sleep` fall at the third main-clock edge after the transition reaches the input and are still high at the second.
- R9: `sleep` is high only when the counter is at 15 and the sleep enable, the auto power-down enable and the idle-level bit are all 1. With the idle level set to low, `sleep` stays 0 while `pd` is high.
- R10: While `cs_n` is 1, `pd` is 1 and `bus_en` is 0 with no clock delay. While `cs_n` is 0, `bus_en` is 1.
- R11: `sleep` is never 1 while `pd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock; all state runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| apd_clk_pin | input | 1 | External slow clock used as tick source when selected |
| ale | input | 1 | Address-latch-enable strobe from the host bus |
| cs_n | input | 1 | Active-low chip select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 = mode register 0, 1 = mode register 1 |
| wr_data | input | 8 | Register write data |
| pd | output | 1 | Power-down request |
| sleep | output | 1 | Deeper sleep request |
| bus_en | output | 1 | Bus-gate enable for address and control inputs |

## Verification
On every cycle the assertions check that sleep never appears without power-down, that a high chip select forces power-down and closes the bus gate, that a disabled function never raises power-down, that the counter only steps by one or clears, that it holds at fifteen, and that an ALE transition empties it. Only the bench scenarios can show the exact tick on which power-down rises for each clock source and idle level, that the external pin and not the main clock drives the count, the release latency after ALE moves, and which mode bits qualify sleep.

// File: rtl/apd_pkg.sv
package apd_pkg;
  localparam int REG0_POL_BIT   = 1;
  localparam int REG0_EN_BIT    = 2;
  localparam int REG0_SLEEP_BIT = 3;
  localparam int REG1_CSEL_BIT  = 0;

  typedef struct packed {
    logic idle_pol;
    logic apd_en;
    logic sleep_en;
    logic main_tick;
  } apd_cfg_t;
endpackage

// File: rtl/apd_sync.sv
module apd_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else if (g == 0) stage_q[g] <= d_in;
        else stage_q[g] <= stage_q[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/apd_regs.sv
module apd_regs
  import apd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output apd_cfg_t          cfg
);
  logic [DATA_W-1:0] mode0_q, mode0_d;
  logic [DATA_W-1:0] mode1_q, mode1_d;

  always_comb begin
    mode0_d = mode0_q;
    mode1_d = mode1_q;
    if (wr_en && !wr_addr) mode0_d = wr_data;
    if (wr_en && wr_addr)  mode1_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode0_q <= '0;
      mode1_q <= '0;
    end else begin
      mode0_q <= mode0_d;
      mode1_q <= mode1_d;
    end
  end

  assign cfg.idle_pol  = mode0_q[REG0_POL_BIT];
  assign cfg.apd_en    = mode0_q[REG0_EN_BIT];
  assign cfg.sleep_en  = mode0_q[REG0_SLEEP_BIT];
  assign cfg.main_tick = mode1_q[REG1_CSEL_BIT];
endmodule

// File: rtl/apd_idle_cnt.sv
module apd_idle_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr) cnt_d = '0;
    else if (tick && (cnt != CNT_MAX)) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign full = (cnt == CNT_MAX);
endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl
  import apd_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_main,
  input  logic              rst_n,
  input  logic              apd_clk_pin,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pd,
  output logic              sleep,
  output logic              bus_en
);
  logic [1:0]       rst_pipe;
  logic             rst_n_int;
  apd_cfg_t         cfg;
  logic [1:0]       raw_in, synced;
  logic             ale_s, ext_s;
  logic             ale_prev, ext_prev;
  logic             ale_edge, ext_rise;
  logic             idle_lvl, tick, cnt_clr;
  logic [CNT_W-1:0] cnt;
  logic             cnt_full, auto_pd;

  always_ff @(posedge clk_main or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  apd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk_main), .rst_n(rst_n_int), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg)
  );

  assign raw_in = {apd_clk_pin, ale};
  apd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_main), .rst_n(rst_n_int), .d_in(raw_in), .d_out(synced)
  );
  assign ale_s = synced[0];
  assign ext_s = synced[1];

  always_ff @(posedge clk_main or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ale_prev <= 1'b0;
      ext_prev <= 1'b0;
    end else begin
      ale_prev <= ale_s;
      ext_prev <= ext_s;
    end
  end

  assign ale_edge = ale_s ^ ale_prev;
  assign ext_rise = ext_s & ~ext_prev;
  assign idle_lvl = (ale_s == cfg.idle_pol);
  assign tick     = cfg.main_tick | ext_rise;
  assign cnt_clr  = ~cfg.apd_en | ale_edge | ~idle_lvl;

  apd_idle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk_main), .rst_n(rst_n_int), .clr(cnt_clr),
    .tick(tick), .cnt(cnt), .full(cnt_full)
  );

  assign auto_pd = cnt_full & cfg.apd_en;
  assign pd      = cs_n | auto_pd;
  assign sleep   = auto_pd & cfg.sleep_en & cfg.idle_pol;
  assign bus_en  = ~cs_n;
endmodule

// File: rtl/apd_ctrl_chk.sv
module apd_ctrl_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             sync_rst_n,
  input logic             cs_n,
  input logic             pd,
  input logic             sleep,
  input logic             bus_en,
  input logic [CNT_W-1:0] cnt,
  input logic             ale_edge,
  input logic             apd_en
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r11_sleep_needs_pd: assert property (@(posedge clk) disable iff (!sync_rst_n)
    sleep |-> pd);

  a_r10_cs_forces_pd: assert property (@(posedge clk) disable iff (!sync_rst_n)
    cs_n |-> (pd && !bus_en));

  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!sync_rst_n)
    (!apd_en && !cs_n) |-> !pd);

  a_r4_single_step: assert property (@(posedge clk) disable iff (!sync_rst_n)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + CNT_ONE) || (cnt == '0)));

  a_r7_saturate: assert property (@(posedge clk) disable iff (!sync_rst_n)
    ($past(cnt) == CNT_MAX) |-> ((cnt == CNT_MAX) || (cnt == '0)));

  a_r8_edge_clears: assert property (@(posedge clk) disable iff (!sync_rst_n)
    ale_edge |=> (cnt == '0));
endmodule

bind apd_ctrl apd_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk_main), .sync_rst_n(rst_n_int), .cs_n(cs_n), .pd(pd),
  .sleep(sleep), .bus_en(bus_en), .cnt(cnt), .ale_edge(ale_edge),
  .apd_en(cfg.apd_en)
);

// File: tb/tb_apd_ctrl.sv
module tb_apd_ctrl;
  logic       clk_main = 1'b0;
  logic       rst_n, apd_clk_pin, ale, cs_n, wr_en, wr_addr;
  logic [7:0] wr_data;
  logic       pd, sleep, bus_en;
  int         checks = 0;
  int         failures = 0;
  bit         done = 0;

  apd_ctrl dut (
    .clk_main(clk_main), .rst_n(rst_n), .apd_clk_pin(apd_clk_pin),
    .ale(ale), .cs_n(cs_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pd(pd), .sleep(sleep), .bus_en(bus_en)
  );

  always #5 clk_main = ~clk_main;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_main);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_main);
    wr_en = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_main);
  endtask

  task automatic ext_pulse();
    apd_clk_pin = 1'b1; cycles(2);
    apd_clk_pin = 1'b0; cycles(2);
  endtask

  task automatic t_reset();
    check("R1 pd after reset", pd, 1'b0);
    check("R1 sleep after reset", sleep, 1'b0);
    check("R1 bus_en after reset", bus_en, 1'b1);
  endtask

  task automatic t_chip_select();
    @(negedge clk_main); cs_n = 1'b1; #1;
    check("R10 pd forced by cs_n", pd, 1'b1);
    check("R10 bus_en closed", bus_en, 1'b0);
    check("R11 no sleep from cs_n", sleep, 1'b0);
    cs_n = 1'b0; #1;
    check("R10 bus_en open", bus_en, 1'b1);
    check("R10 pd released", pd, 1'b0);
  endtask

  task automatic t_disabled();
    wr(1'b1, 8'h05);
    wr(1'b0, 8'h00);
    cycles(40);
    check("R3 disabled no pd", pd, 1'b0);
    check("R2 reg1 bit2 has no effect", pd, 1'b0);
  endtask

  task automatic t_count_main();
    wr(1'b0, 8'h04);
    cycles(14);
    check("R4 pd low after 14 ticks", pd, 1'b0);
    cycles(1);
    check("R4 pd high after 15 ticks", pd, 1'b1);
    check("R9 no sleep when disabled", sleep, 1'b0);
    cycles(40);
    check("R7 pd held saturated", pd, 1'b1);
  endtask

  task automatic t_release();
    ale = 1'b1;
    cycles(2);
    check("R8 pd still high at 2nd edge", pd, 1'b1);
    cycles(1);
    check("R8 pd released at 3rd edge", pd, 1'b0);
    cycles(40);
    check("R6 non-idle level holds pd low", pd, 1'b0);
  endtask

  task automatic t_sleep_high();
    wr(1'b0, 8'h0E);
    cycles(14);
    check("R9 sleep low before overflow", sleep, 1'b0);
    cycles(1);
    check("R4 pd high with idle level high", pd, 1'b1);
    check("R9 sleep high", sleep, 1'b1);
    ale = 1'b0;
    cycles(3);
    check("R8 sleep released", sleep, 1'b0);
    check("R8 pd released after sleep", pd, 1'b0);
  endtask

  task automatic t_sleep_low_pol();
    wr(1'b0, 8'h0C);
    cycles(20);
    check("R9 pd high idle low", pd, 1'b1);
    check("R9 sleep needs idle bit", sleep, 1'b0);
  endtask

  task automatic t_ext_clock();
    wr(1'b1, 8'h00);
    ale = 1'b1; cycles(5);
    ale = 1'b0; cycles(5);
    check("R8 pd cleared before ext test", pd, 1'b0);
    cycles(30);
    check("R5 main clock ignored", pd, 1'b0);
    for (int i = 0; i < 14; i++) ext_pulse();
    cycles(3);
    check("R5 pd low after 14 pin edges", pd, 1'b0);
    ext_pulse();
    cycles(3);
    check("R5 pd high after 15 pin edges", pd, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; apd_clk_pin = 1'b0; ale = 1'b0; cs_n = 1'b0;
    wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
    cycles(4);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_chip_select();
    t_disabled();
    t_count_main();
    t_release();
    t_sleep_high();
    t_sleep_low_pol();
    t_ext_clock();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule